// File: doc/BRIEF.md
# Asynchronous Receive Retiming Buffer

This block sits between a demodulated serial bit stream and a slow host controller that has no UART. It watches the line for a falling edge and confirms a start bit half a bit later. It then samples the nine bits that follow at their centres, using a timebase that divides the system clock down to a 16x oversampling tick. When the ninth bit is in, the whole capture is copied into a holding register, and the search for the next start bit resumes at once.

At the moment of that copy the host strobe is sampled. If the strobe is low, the block asserts an active-low ready output and presents the first held bit on its data output. The host then clocks out the remaining bits with loosely timed strobe pulses. If the strobe is high, retiming counts as switched off and the data output keeps following the incoming line. Whenever no transfer is running, the data output is a live copy of the received stream.

Top module: `rx_retimer`

## Requirements
- R1: After reset the ready output `rdy_n` is high (1), `overrun` is 0, and `data_out` follows the idle-high serial input.
- R2: A character starts only when the input falls from 1 to 0 and is still 0 half a bit period (OSR/2 ticks) later. A low pulse shorter than that is rejected and raises no ready.
- R3: The nine bits after the start bit are sampled at bit centres, one every OSR ticks. The bit received first is the first one presented to the host.
- R4: If the synchronised strobe is low when the ninth bit is captured, `rdy_n` goes low (0) and `data_out` shows the first captured bit.
- R5: If the strobe is high when the ninth bit is captured, `rdy_n` stays high and `data_out` keeps following the serial input.
- R6: `rdy_n` returns high on the first rising edge of the strobe after it was asserted.
- R7: Each of the first eight falling strobe edges of a transfer moves the next captured bit onto `data_out`. The ninth falling edge ends the transfer, and `data_out` follows the serial input again.
- R8: A new start-bit search is armed at the moment of the copy, so a character whose start bit directly follows the previous stop bit is captured and delivered correctly.
- R9: A character that completes while a transfer is still running is discarded, and the held bits stay unchanged. It sets `overrun`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Demodulated serial data, idle high |
| strobe_in | input | 1 | Host strobe, asynchronous to clk |
| rdy_n | output | 1 | Active-low ready: a capture is waiting |
| data_out | output | 1 | Held bit during a transfer, otherwise the live serial input |
| overrun | output | 1 | Sticky flag: a capture was dropped |

## Verification
The bench covers the following corner cases and the failure each one would expose:
- A short low glitch on the idle line. A design without mid-bit confirmation would raise ready and then misalign the next character.
- An all-zero character. Here a transfer released after eight falling edges instead of nine, or a missing final shift, shows up as a wrong last bit or an early return to the idle-high line.
- A character whose start bit follows its predecessor's stop bit with no gap. This catches a design that re-arms the start search late and so loses or shifts the second character.
- A second character arriving before the host has read the first. This must set the sticky overrun flag and leave the first character intact. A design that overwrote the holding register would deliver the wrong bits.

// File: rtl/rx_retimer_pkg.sv
package rx_retimer_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_START = 2'd1,
    CAP_DATA  = 2'd2
  } cap_state_t;

  // Tick index (counted from the falling edge) at which the start bit is re-checked.
  function automatic int start_confirm_tick(input int osr);
    return (osr / 2) - 1;
  endfunction

  // Tick index at which a data bit is sampled, counted from the previous sample.
  function automatic int bit_sample_tick(input int osr);
    return osr - 1;
  endfunction

  // Number of falling strobe edges that move a bit onto the output.
  function automatic int advance_edges(input int nbits);
    return nbits - 1;
  endfunction

endpackage

// File: rtl/rx_retimer_tick.sv
module rx_retimer_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_retimer_sync.sv
module rx_retimer_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_retimer_capture.sv
module rx_retimer_capture
  import rx_retimer_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int NBITS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rx,
  output logic [NBITS-1:0] cap_data,
  output logic             cap_done
);
  localparam int TW = $clog2(OSR);
  localparam int BW = $clog2(NBITS);
  localparam logic [TW-1:0] MID_T  = TW'(start_confirm_tick(OSR));
  localparam logic [TW-1:0] BIT_T  = TW'(bit_sample_tick(OSR));
  localparam logic [BW-1:0] LAST_B = BW'(NBITS - 1);

  cap_state_t      st;
  logic [TW-1:0]   tcnt;
  logic [BW-1:0]   bidx;
  logic            prev_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= CAP_IDLE;
      tcnt     <= '0;
      bidx     <= '0;
      prev_rx  <= 1'b1;
      cap_data <= '0;
      cap_done <= 1'b0;
    end else begin
      cap_done <= 1'b0;
      if (tick) begin
        unique case (st)
          CAP_IDLE: begin
            prev_rx <= rx;
            if (prev_rx && !rx) begin
              st   <= CAP_START;
              tcnt <= '0;
            end
          end
          CAP_START: begin
            if (tcnt == MID_T) begin
              tcnt <= '0;
              bidx <= '0;
              if (!rx) begin
                st <= CAP_DATA;
              end else begin
                st      <= CAP_IDLE;
                prev_rx <= rx;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          CAP_DATA: begin
            if (tcnt == BIT_T) begin
              tcnt     <= '0;
              cap_data <= {rx, cap_data[NBITS-1:1]};
              if (bidx == LAST_B) begin
                cap_done <= 1'b1;
                st       <= CAP_IDLE;
                prev_rx  <= rx;
              end else begin
                bidx <= bidx + 1'b1;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          default: st <= CAP_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_retimer_hold.sv
module rx_retimer_hold
  import rx_retimer_pkg::*;
#(
  parameter int NBITS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_done,
  input  logic [NBITS-1:0] cap_data,
  input  logic             strb,
  input  logic             rx,
  output logic             rdy_n,
  output logic             data_out,
  output logic             overrun,
  output logic             active,
  output logic             load_evt,
  output logic             drop_evt,
  output logic             strb_rise,
  output logic             strb_fall,
  output logic [NBITS-1:0] hold_word
);
  localparam int FW = $clog2(NBITS);
  localparam logic [FW-1:0] LAST_F = FW'(advance_edges(NBITS));

  logic          strb_q;
  logic [FW-1:0] fcnt;

  assign strb_rise = strb & ~strb_q;
  assign strb_fall = ~strb & strb_q;
  assign load_evt  = cap_done & ~active;
  assign drop_evt  = cap_done & active;
  assign data_out  = active ? hold_word[0] : rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q    <= 1'b0;
      hold_word <= '0;
      active    <= 1'b0;
      rdy_n     <= 1'b1;
      fcnt      <= '0;
      overrun   <= 1'b0;
    end else begin
      strb_q <= strb;
      if (drop_evt) overrun <= 1'b1;
      if (load_evt) begin
        hold_word <= cap_data;
        fcnt      <= '0;
        if (!strb) begin
          active <= 1'b1;
          rdy_n  <= 1'b0;
        end
      end else if (active) begin
        if (strb_rise) rdy_n <= 1'b1;
        if (strb_fall) begin
          if (fcnt == LAST_F) begin
            active <= 1'b0;
          end else begin
            hold_word <= hold_word >> 1;
            fcnt      <= fcnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rx_retimer.sv
module rx_retimer #(
  parameter int DIV   = 4,
  parameter int OSR   = 16,
  parameter int NBITS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  input  logic strobe_in,
  output logic rdy_n,
  output logic data_out,
  output logic overrun
);
  logic             tick;
  logic             rx_s;
  logic             strb_s;
  logic [NBITS-1:0] cap_data;
  logic             cap_done;
  logic             active;
  logic             load_evt;
  logic             drop_evt;
  logic             strb_rise;
  logic             strb_fall;
  logic [NBITS-1:0] hold_word;

  rx_retimer_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  rx_retimer_sync #(.STAGES(2), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s)
  );

  rx_retimer_sync #(.STAGES(2), .RST_VAL(1'b0)) u_strb_sync (
    .clk(clk), .rst_n(rst_n), .d(strobe_in), .q(strb_s)
  );

  rx_retimer_capture #(.OSR(OSR), .NBITS(NBITS)) u_cap (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s),
    .cap_data(cap_data), .cap_done(cap_done)
  );

  rx_retimer_hold #(.NBITS(NBITS)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap_done(cap_done), .cap_data(cap_data),
    .strb(strb_s), .rx(rx_s), .rdy_n(rdy_n), .data_out(data_out),
    .overrun(overrun), .active(active), .load_evt(load_evt),
    .drop_evt(drop_evt), .strb_rise(strb_rise), .strb_fall(strb_fall),
    .hold_word(hold_word)
  );
endmodule

// File: rtl/rx_retimer_chk.sv
module rx_retimer_chk #(
  parameter int NBITS = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rdy_n,
  input logic             overrun,
  input logic             active,
  input logic             load_evt,
  input logic             drop_evt,
  input logic             strb_s,
  input logic             strb_rise,
  input logic             strb_fall,
  input logic             cap_done,
  input logic [NBITS-1:0] hold_word
);
  // R1: ready is only ever low inside a transfer
  a_r1_ready_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |-> active);

  // R3: a capture completion is a single-cycle event
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |=> !cap_done);

  // R4: copy with the strobe low asserts ready
  a_r4_armed_ready: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && !strb_s |=> !rdy_n && active);

  // R5: copy with the strobe high leaves retiming off
  a_r5_disarmed_pass: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && strb_s |=> rdy_n && !active);

  // R6: a strobe rise during a transfer clears ready
  a_r6_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
    active && strb_rise |=> rdy_n);

  // R7: held bits move only on a falling strobe edge
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    active && !strb_fall |=> $stable(hold_word));

  // R9: a dropped capture raises overrun and does not touch the held bits
  a_r9_drop_keeps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt && !strb_fall |=> overrun && $stable(hold_word));

  // R9: overrun is sticky
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind rx_retimer rx_retimer_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy_n(rdy_n), .overrun(overrun),
  .active(active), .load_evt(load_evt), .drop_evt(drop_evt),
  .strb_s(strb_s), .strb_rise(strb_rise), .strb_fall(strb_fall),
  .cap_done(cap_done), .hold_word(hold_word)
);

// File: tb/sim_rx_retimer.sv
module sim_rx_retimer;
  localparam int DIV   = 4;
  localparam int OSR   = 16;
  localparam int NBITS = 9;
  localparam int BITCLK = DIV * OSR;

  // {arm, data}: arm=1 keeps the strobe low at capture time
  localparam logic [9:0] VECS [8] = '{
    {1'b1, 9'h155}, {1'b1, 9'h0AA}, {1'b1, 9'h1FF}, {1'b1, 9'h000},
    {1'b1, 9'h13C}, {1'b0, 9'h0B5}, {1'b1, 9'h001}, {1'b1, 9'h100}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in = 1'b1;
  logic strobe_in = 1'b0;
  logic rdy_n, data_out, overrun;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  rx_retimer #(.DIV(DIV), .OSR(OSR), .NBITS(NBITS)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .strobe_in(strobe_in),
    .rdy_n(rdy_n), .data_out(data_out), .overrun(overrun)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // Start bit, nine bits first-received-first, one stop bit.
  // With watch=1, data_out is compared to the line at each bit centre (R5).
  task automatic send_char(input logic [8:0] d, input logic watch);
    @(negedge clk); rx_in = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < NBITS; i++) begin
      rx_in = d[i];
      repeat (BITCLK / 2) @(negedge clk);
      if (watch) chk(data_out == d[i], "R5 pass-through", data_out, d[i]);
      repeat (BITCLK - BITCLK / 2) @(negedge clk);
    end
    rx_in = 1'b1;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic wait_rdy();
    int n = 0;
    while (rdy_n && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic read_char(input logic [8:0] d, input string tag);
    wait_rdy();
    chk(rdy_n == 1'b0, {"R4 ready ", tag}, rdy_n, 0);
    chk(data_out == d[0], {"R3 first bit ", tag}, data_out, d[0]);
    for (int i = 0; i < NBITS; i++) begin
      strobe_in = 1'b1;
      repeat (8) @(negedge clk);
      if (i == 0) chk(rdy_n == 1'b1, {"R6 ready clears ", tag}, rdy_n, 1);
      strobe_in = 1'b0;
      repeat (8) @(negedge clk);
      if (i < NBITS - 1)
        chk(data_out == d[i+1], {"R7 next bit ", tag}, data_out, d[i+1]);
    end
    chk(data_out == rx_in, {"R7 released ", tag}, data_out, rx_in);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(rdy_n == 1'b1, "R1 rdy_n", rdy_n, 1);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);
    chk(data_out == 1'b1, "R1 data_out idle", data_out, 1);

    // Vector table
    for (int v = 0; v < 8; v++) begin
      if (VECS[v][9]) begin
        strobe_in = 1'b0;
        send_char(VECS[v][8:0], 1'b0);
        read_char(VECS[v][8:0], "table");
      end else begin
        strobe_in = 1'b1;
        repeat (8) @(negedge clk);
        send_char(VECS[v][8:0], 1'b1);
        repeat (100) @(negedge clk);
        chk(rdy_n == 1'b1, "R5 no ready", rdy_n, 1);
        strobe_in = 1'b0;
        repeat (8) @(negedge clk);
      end
    end

    // R2 glitch rejection, then a clean character still aligns
    @(negedge clk); rx_in = 1'b0;
    repeat (BITCLK / 4) @(negedge clk);
    rx_in = 1'b1;
    repeat (BITCLK * 12) @(negedge clk);
    chk(rdy_n == 1'b1, "R2 glitch rejected", rdy_n, 1);
    send_char(9'h0C9, 1'b0);
    read_char(9'h0C9, "R2 after glitch");

    // R8 back-to-back characters, host reads the first during the second
    fork
      begin
        send_char(9'h1A3, 1'b0);
        send_char(9'h05C, 1'b0);
      end
      begin
        read_char(9'h1A3, "R8 first");
        read_char(9'h05C, "R8 second");
      end
    join

    // R9 overrun: second character arrives before the first is read
    send_char(9'h12D, 1'b0);
    wait_rdy();
    send_char(9'h0F0, 1'b0);
    repeat (100) @(negedge clk);
    chk(overrun == 1'b1, "R9 overrun set", overrun, 1);
    read_char(9'h12D, "R9 held kept");
    chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);
    do_reset();
    chk(overrun == 1'b0, "R9 overrun cleared by reset", overrun, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule